// File: doc/BRIEF.md
# Static Memory Write Cycle Generator

This block turns one internal write request into one complete write cycle on an external asynchronous static memory bus. A request carries a byte address, a data word and byte enables. Once it is accepted, the block drives a chip select, a single write strobe, per-byte write strobes and active-low byte selects. It also drives the address, the data word and a data output-enable. Every edge falls on the system clock. The chip select and the write strobe each follow their own setup, pulse and hold phases, taken from programmed counts. A separate total count sets how long the whole cycle lasts.

A mode input chooses which strobe governs the data bus. When the write-strobe timing is in control, the data drivers turn on when the write-strobe setup has elapsed. When the chip-select timing is in control, they turn on when the chip-select setup has elapsed. In both cases they stay on until the last clock of the cycle, and the waveform of the other strobe has no bearing on them. A done pulse marks the last clock of the cycle. Integrators use the per-byte strobes for byte-wide devices. For devices with byte lanes, they use the single strobe together with the byte selects.

Top module: `smem_wr_gen`

## Requirements
- R1: `req_ready` is 1 only when no cycle is in progress. A request (`req_valid`=1 while `req_ready`=1 at a rising edge) starts a cycle. `req_ready` stays 0 for every clock of that cycle and returns to 1 on the clock after `done`.
- R2: A cycle lasts exactly T clocks, numbered 0 to T-1 from the clock after the accepting edge, with T = `cfg_cycle`. `done` is 1 only in clock T-1.
- R3: `mem_we_n` is 0 exactly in clocks k with `cfg_we_setup` <= k < `cfg_we_setup`+`cfg_we_pulse`, and 1 otherwise. A pulse count of 0 gives no low clock.
- R4: `mem_cs_n` is 0 exactly in clocks k with `cfg_cs_setup` <= k < `cfg_cs_setup`+`cfg_cs_pulse`, and 1 otherwise.
- R5: With `cfg_nwe_ctrl`=1, `mem_d_oe` is 1 exactly in clocks `cfg_we_setup` through T-1, whatever the chip-select timing is.
- R6: With `cfg_nwe_ctrl`=0, `mem_d_oe` is 1 exactly in clocks `cfg_cs_setup` through T-1, whatever the write-strobe timing is.
- R7: During a cycle, `mem_a` equals the request address and `mem_d` equals the request data. Both hold steady for the whole cycle.
- R8: Bit i of `mem_bs_n` is the inverse of request enable bit i for the whole cycle, and all its bits are 1 when idle. Bit i of `mem_wr_n` is 0 exactly when `mem_we_n` is 0 and enable bit i is 1.
- R9: After reset, `mem_cs_n`, `mem_we_n`, `mem_wr_n` and `mem_bs_n` are all ones, `mem_d_oe` and `done` are 0, and `req_ready` is 1.
- R10: A total count of 0 behaves as a count of 1. The cycle is one clock long and `done` is 1 in it.
- R11: Timing and mode inputs are captured at the accepting edge. Changing them during a cycle has no effect on that cycle's waveforms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Byte address of the write |
| req_data | input | DATA_W | Write data word |
| req_be | input | DATA_W/8 | Byte enables, bit i for byte lane i |
| cfg_nwe_ctrl | input | 1 | 1: write-strobe timing governs data; 0: chip-select timing governs data |
| cfg_we_setup | input | CNT_W | Write-strobe setup clocks |
| cfg_we_pulse | input | CNT_W | Write-strobe low clocks |
| cfg_cs_setup | input | CNT_W | Chip-select setup clocks |
| cfg_cs_pulse | input | CNT_W | Chip-select low clocks |
| cfg_cycle | input | CNT_W | Total cycle clocks |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Single write strobe, active low |
| mem_wr_n | output | DATA_W/8 | Per-byte write strobes, active low |
| mem_bs_n | output | DATA_W/8 | Byte selects, active low |
| mem_a | output | ADDR_W | Address, low bits included |
| mem_d | output | DATA_W | Write data |
| mem_d_oe | output | 1 | Data bus drive enable |
| done | output | 1 | Last clock of the cycle |

## Verification
On every clock, the assertions check the following. The output-enable never drops before `done`, and it is off on the clock after `done`. Address, data and byte selects do not move inside a cycle. The per-byte strobes never go low while the single strobe is high. The latched timing stays put while a cycle runs. The following can be shown only by the bench's directed scenarios, which compare each clock with a window computed from the programmed counts: that the output-enable opens in exactly the right clock for each mode setting, that each strobe is low for exactly its pulse count, and that the zero-length cycle and a mid-cycle change of settings behave as required.

// File: rtl/smw_pkg.sv
package smw_pkg;
  localparam int unsigned SMW_CNT_W = 6;
  localparam int unsigned SMW_NSTRB = 2;
  localparam int unsigned SEL_WE = 0;
  localparam int unsigned SEL_CS = 1;

  typedef logic [SMW_CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic nwe_ctrl;
    cnt_t we_setup;
    cnt_t we_pulse;
    cnt_t cs_setup;
    cnt_t cs_pulse;
    cnt_t cycle;
  } smw_cfg_t;

  function automatic cnt_t last_index(input cnt_t total);
    return (total == '0) ? '0 : total - cnt_t'(1);
  endfunction
endpackage

// File: rtl/smw_cfg_hold.sv
module smw_cfg_hold
  import smw_pkg::*;
#(
  parameter int unsigned BE_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            busy,
  input  smw_cfg_t        cfg_in,
  input  logic [BE_W-1:0] be_in,
  output smw_cfg_t        cfg_use,
  output logic [BE_W-1:0] be_use
);
  smw_cfg_t        cfg_q;
  logic [BE_W-1:0] be_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      be_q  <= '0;
    end else if (start) begin
      cfg_q <= cfg_in;
      be_q  <= be_in;
    end
  end

  assign cfg_use = start ? cfg_in : cfg_q;
  assign be_use  = start ? be_in  : be_q;

  // R11
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !start) |=> ($stable(cfg_q) && $stable(be_q)));
endmodule

// File: rtl/smw_seq.sv
module smw_seq
  import smw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  cnt_t last_idx,
  output logic busy,
  output cnt_t cnt,
  output logic nxt_busy,
  output cnt_t nxt_k
);
  always_comb begin
    if (start) begin
      nxt_busy = 1'b1;
      nxt_k    = '0;
    end else begin
      nxt_busy = busy && (cnt != last_idx);
      nxt_k    = cnt + cnt_t'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      busy <= nxt_busy;
      cnt  <= nxt_busy ? nxt_k : '0;
    end
  end

  // R1
  no_start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);
endmodule

// File: rtl/smw_phase.sv
module smw_phase
  import smw_pkg::*;
(
  input  logic active_cycle,
  input  cnt_t k,
  input  cnt_t setup,
  input  cnt_t pulse,
  output logic in_pulse,
  output logic past_setup
);
  logic [SMW_CNT_W:0] pulse_end;

  always_comb begin
    pulse_end  = {1'b0, setup} + {1'b0, pulse};
    past_setup = active_cycle && (k >= setup);
    in_pulse   = past_setup && ({1'b0, k} < pulse_end);
  end
endmodule

// File: rtl/smem_wr_gen.sv
module smem_wr_gen
  import smw_pkg::*;
#(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = SMW_CNT_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_data,
  input  logic [DATA_W/8-1:0]      req_be,
  input  logic                     cfg_nwe_ctrl,
  input  logic [CNT_W-1:0]         cfg_we_setup,
  input  logic [CNT_W-1:0]         cfg_we_pulse,
  input  logic [CNT_W-1:0]         cfg_cs_setup,
  input  logic [CNT_W-1:0]         cfg_cs_pulse,
  input  logic [CNT_W-1:0]         cfg_cycle,
  output logic                     mem_cs_n,
  output logic                     mem_we_n,
  output logic [DATA_W/8-1:0]      mem_wr_n,
  output logic [DATA_W/8-1:0]      mem_bs_n,
  output logic [ADDR_W-1:0]        mem_a,
  output logic [DATA_W-1:0]        mem_d,
  output logic                     mem_d_oe,
  output logic                     done
);
  localparam int unsigned BE_W = DATA_W / 8;

  smw_cfg_t        cfg_in, cfg_use;
  logic [BE_W-1:0] be_use;
  logic            busy, start, nxt_busy;
  cnt_t            cnt, nxt_k, last_use;
  cnt_t            st_setup [SMW_NSTRB];
  cnt_t            st_pulse [SMW_NSTRB];
  logic [SMW_NSTRB-1:0] st_low, st_armed;
  logic            oe_nxt;

  assign cfg_in = '{nwe_ctrl: cfg_nwe_ctrl, we_setup: cfg_we_setup,
                    we_pulse: cfg_we_pulse, cs_setup: cfg_cs_setup,
                    cs_pulse: cfg_cs_pulse, cycle: cfg_cycle};

  assign start     = req_valid && !busy;
  assign req_ready = !busy;

  smw_cfg_hold #(.BE_W(BE_W)) u_hold (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .cfg_in(cfg_in), .be_in(req_be),
    .cfg_use(cfg_use), .be_use(be_use)
  );

  assign last_use = last_index(cfg_use.cycle);

  smw_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .last_idx(last_use),
    .busy(busy), .cnt(cnt), .nxt_busy(nxt_busy), .nxt_k(nxt_k)
  );

  assign st_setup[SEL_WE] = cfg_use.we_setup;
  assign st_pulse[SEL_WE] = cfg_use.we_pulse;
  assign st_setup[SEL_CS] = cfg_use.cs_setup;
  assign st_pulse[SEL_CS] = cfg_use.cs_pulse;

  for (genvar s = 0; s < SMW_NSTRB; s++) begin : g_strobe
    smw_phase u_phase (
      .active_cycle(nxt_busy), .k(nxt_k),
      .setup(st_setup[s]), .pulse(st_pulse[s]),
      .in_pulse(st_low[s]), .past_setup(st_armed[s])
    );
  end

  assign oe_nxt = cfg_use.nwe_ctrl ? st_armed[SEL_WE] : st_armed[SEL_CS];

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_cs_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_wr_n <= '1;
      mem_bs_n <= '1;
      mem_a    <= '0;
      mem_d    <= '0;
      mem_d_oe <= 1'b0;
      done     <= 1'b0;
    end else begin
      mem_cs_n <= !st_low[SEL_CS];
      mem_we_n <= !st_low[SEL_WE];
      mem_wr_n <= ~({BE_W{st_low[SEL_WE]}} & be_use);
      mem_bs_n <= nxt_busy ? ~be_use : '1;
      mem_d_oe <= oe_nxt;
      done     <= nxt_busy && (nxt_k == last_use);
      if (start) begin
        mem_a <= req_addr;
        mem_d <= req_data;
      end
    end
  end

  // R5
  oe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_d_oe && !done) |=> mem_d_oe);

  // R2
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!mem_d_oe && req_ready && mem_cs_n && mem_we_n));

  // R7
  bus_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> ($stable(mem_a) && $stable(mem_d) && $stable(mem_bs_n)));

  // R8
  byte_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we_n |-> (&mem_wr_n));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (mem_cs_n && mem_we_n && !mem_d_oe && !done && (&mem_bs_n)));
endmodule

// File: tb/smem_wr_gen_tb.sv
`timescale 1ns/1ps
module smem_wr_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [25:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic [3:0]  req_be = '0;
  logic        cfg_nwe_ctrl = 1'b0;
  logic [5:0]  cfg_we_setup = '0, cfg_we_pulse = '0;
  logic [5:0]  cfg_cs_setup = '0, cfg_cs_pulse = '0, cfg_cycle = '0;
  logic        mem_cs_n, mem_we_n, mem_d_oe, done;
  logic [3:0]  mem_wr_n, mem_bs_n;
  logic [25:0] mem_a;
  logic [31:0] mem_d;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  smem_wr_gen u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
    .cfg_nwe_ctrl(cfg_nwe_ctrl), .cfg_we_setup(cfg_we_setup),
    .cfg_we_pulse(cfg_we_pulse), .cfg_cs_setup(cfg_cs_setup),
    .cfg_cs_pulse(cfg_cs_pulse), .cfg_cycle(cfg_cycle),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_wr_n(mem_wr_n),
    .mem_bs_n(mem_bs_n), .mem_a(mem_a), .mem_d(mem_d),
    .mem_d_oe(mem_d_oe), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // One full write cycle; expected values from the programmed counts.
  // change_mid: alter the cfg inputs in clock 1 (R11).
  task automatic run_write(input bit mode, input int ws, input int wp,
                           input int cs, input int cp, input int tot,
                           input logic [25:0] a, input logic [31:0] d,
                           input logic [3:0] be, input bit change_mid,
                           input string name);
    int t_eff;
    int ctrl_setup;
    int we_low;
    int cs_low;
    t_eff = (tot == 0) ? 1 : tot;
    ctrl_setup = mode ? ws : cs;
    we_low = 0;
    cs_low = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, {name, " R1 ready before request"}, 32'(req_ready), 1);
    cfg_nwe_ctrl = mode;
    cfg_we_setup = 6'(ws); cfg_we_pulse = 6'(wp);
    cfg_cs_setup = 6'(cs); cfg_cs_pulse = 6'(cp);
    cfg_cycle = 6'(tot);
    req_addr = a; req_data = d; req_be = be; req_valid = 1'b1;
    for (int k = 0; k < t_eff; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (change_mid && k == 1) begin
        cfg_nwe_ctrl = ~mode;
        cfg_we_setup = 6'd0; cfg_we_pulse = 6'd1;
        cfg_cs_setup = 6'd0; cfg_cs_pulse = 6'd1;
        cfg_cycle = 6'd2; req_be = ~be;
      end
      begin
        bit exp_we_low, exp_cs_low, exp_oe, exp_done;
        logic [3:0] exp_wr;
        exp_we_low = (k >= ws) && (k < ws + wp);
        exp_cs_low = (k >= cs) && (k < cs + cp);
        exp_oe     = (k >= ctrl_setup);
        exp_done   = (k == t_eff - 1);
        exp_wr     = exp_we_low ? ~be : 4'hF;
        if (!mem_we_n) we_low++;
        if (!mem_cs_n) cs_low++;
        chk(mem_we_n == !exp_we_low, {name, " R3 we_n window"}, 32'(mem_we_n), 32'(!exp_we_low));
        chk(mem_cs_n == !exp_cs_low, {name, " R4 cs_n window"}, 32'(mem_cs_n), 32'(!exp_cs_low));
        if (mode)
          chk(mem_d_oe == exp_oe, {name, " R5 oe window"}, 32'(mem_d_oe), 32'(exp_oe));
        else
          chk(mem_d_oe == exp_oe, {name, " R6 oe window"}, 32'(mem_d_oe), 32'(exp_oe));
        chk(done == exp_done, {name, " R2 done position"}, 32'(done), 32'(exp_done));
        chk(req_ready == 1'b0, {name, " R1 ready low in cycle"}, 32'(req_ready), 0);
        chk(mem_a == a, {name, " R7 address"}, 32'(mem_a), 32'(a));
        chk(mem_d == d, {name, " R7 data"}, mem_d, d);
        chk(mem_bs_n == ~be, {name, " R8 byte selects"}, 32'(mem_bs_n), 32'(~be));
        chk(mem_wr_n == exp_wr, {name, " R8 byte strobes"}, 32'(mem_wr_n), 32'(exp_wr));
      end
    end
    chk(we_low == wp, {name, " R3 we pulse width"}, 32'(we_low), 32'(wp));
    chk(cs_low == cp, {name, " R4 cs pulse width"}, 32'(cs_low), 32'(cp));
    @(negedge clk);
    chk(req_ready == 1'b1, {name, " R1 ready after done"}, 32'(req_ready), 1);
    chk(mem_d_oe == 1'b0, {name, " R5 oe off after cycle"}, 32'(mem_d_oe), 0);
    chk(mem_bs_n == 4'hF, {name, " R8 byte selects idle"}, 32'(mem_bs_n), 32'hF);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_we_n, "R9 strobes high in reset", {30'd0, mem_cs_n, mem_we_n}, 3);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_cs_n && mem_we_n, "R9 strobes high after reset", {30'd0, mem_cs_n, mem_we_n}, 3);
    chk(mem_wr_n == 4'hF && mem_bs_n == 4'hF, "R9 byte lines high",
        {24'd0, mem_wr_n, mem_bs_n}, 32'hFF);
    chk(!mem_d_oe && !done, "R9 oe and done low", {30'd0, mem_d_oe, done}, 0);
    chk(req_ready == 1'b1, "R9 ready after reset", 32'(req_ready), 1);
  endtask

  task automatic test_idle_request_ignored_when_low();
    repeat (4) @(negedge clk);
    chk(mem_cs_n && !mem_d_oe && req_ready, "R1 no cycle without request",
        {29'd0, mem_cs_n, mem_d_oe, req_ready}, 32'b101);
  endtask

  initial begin
    test_reset();
    test_idle_request_ignored_when_low();
    run_write(1'b1, 2, 3, 1, 5, 8, 26'h2ABCDE4, 32'hDEADBEEF, 4'hF, 1'b0, "we_ctrl");
    run_write(1'b0, 2, 3, 1, 5, 8, 26'h0001230, 32'h12345678, 4'hF, 1'b0, "cs_ctrl");
    run_write(1'b0, 0, 2, 3, 2, 7, 26'h3FFFFFC, 32'hA5A55A5A, 4'hC, 1'b0, "cs_late");
    run_write(1'b1, 1, 2, 0, 6, 7, 26'h0000002, 32'h00FF00FF, 4'b0101, 1'b0, "byte_lanes");
    run_write(1'b1, 3, 0, 0, 4, 4, 26'h1000000, 32'hCAFEF00D, 4'b0011, 1'b0, "no_we_pulse");
    run_write(1'b1, 0, 1, 0, 1, 0, 26'h0000010, 32'h0BADC0DE, 4'hF, 1'b0, "R10_zero_len");
    run_write(1'b0, 3, 2, 4, 3, 9, 26'h0ABCDE0, 32'h87654321, 4'b1001, 1'b1, "R11_mid_change");
    run_write(1'b1, 0, 5, 0, 5, 5, 26'h0000100, 32'hFFFF0000, 4'hF, 1'b0, "full_span");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule